// File: doc/BRIEF.md
# Transform Frame Input Gate

This block sits between a signal detector and a streaming transform engine. The detector provides a start line and a sample stream. The stream carries zeros whenever no signal is present. The gate waits for a rising edge on the start line and then opens a frame. It emits exactly `LEN` output beats, each tagged with its position in the frame. A pulse marks the end of the frame so the transform can run on a complete block.

Each output beat takes the detector sample when the input is valid, and zero when it is not. A burst shorter than the frame is therefore padded to full length with zeros.

The output side is a valid/ready stream. While a frame is open, `out_valid` stays high. A beat transfers only in a cycle where `out_ready` is also high. When `out_ready` is low, the index and the markers hold their values and no input sample is consumed. The input side sees `in_ready` high only in cycles where an output beat transfers. A detector sample is therefore consumed exactly when it leaves as a beat. Start edges that arrive while a frame is being filled are discarded.

Top module: `fft_frame_gate`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `frame_done` stay low until the first rising edge of `det_start`. A `det_start` that is already high at reset release does not count as an edge.
- R2: A rising edge of `det_start` seen at a clock edge while idle makes `out_valid` high from that edge on, with `out_index` 0. A `det_start` held high opens no further frame after the current one completes.
- R3: A rising edge of `det_start` while a frame is open is ignored, including one in the cycle of the last transfer. The index continues and the frame still ends after `LEN` transfers.
- R4: A transfer happens in a cycle with `out_valid` and `out_ready` both high. `out_index` starts at 0 and goes up by one on each transfer, up to `LEN-1`.
- R5: `out_first` is high exactly on beats with index 0. `out_last` is high exactly on beats with index `LEN-1`. Both markers are qualified by `out_valid`.
- R6: While a frame is open, `out_data` equals `in_data` when `in_valid` is 1 and equals zero when `in_valid` is 0. `in_ready` equals `out_valid & out_ready`.
- R7: While `out_ready` is low, `out_valid` stays high and `out_index` does not change.
- R8: `frame_done` is a one-cycle pulse in the cycle after the transfer of index `LEN-1`. In that cycle `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_start | input | 1 | Detector start line; a rising edge opens a frame |
| in_valid | input | 1 | Detector sample present |
| in_data | input | DW | Detector sample |
| in_ready | output | 1 | Sample consumed this cycle |
| out_valid | output | 1 | Frame beat available |
| out_ready | input | 1 | Transform engine accepts the beat |
| out_data | output | DW | Beat sample, zero when padded |
| out_index | output | $clog2(LEN) | Position of the beat in the frame |
| out_first | output | 1 | Beat is index 0 |
| out_last | output | 1 | Beat is index LEN-1 |
| frame_done | output | 1 | Pulse after the final transfer of a frame |

## Verification
The bench sweeps bursts with 8, 0, 2, 4 and 6 valid samples through an 8-beat frame. Comparing beat data against an arithmetic pattern separates forwarded samples from zero padding.

Each burst length is paired with a different ready pattern, from always-ready to sparse stalls. This shows whether the index and the markers advance only on real transfers.

Start edges are injected in the middle of a frame and in the cycle of the last transfer. The start line is also held high across frame completion. Together these show the difference between edge triggering and level triggering, and show that open frames are protected from restarts.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic {
    FG_IDLE = 1'b0,
    FG_FILL = 1'b1
  } fg_state_e;
endpackage

// File: rtl/fg_edge_detect.sv
module fg_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  // Reset to 1 so that a line already high at reset release is not taken as an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/fg_frame_ctrl.sv
module fg_frame_ctrl
  import fg_pkg::*;
#(
  parameter int LEN = 1024,
  parameter int IW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_req,
  input  logic          beat_ok,
  output logic          active,
  output logic [IW-1:0] index,
  output logic          first,
  output logic          last,
  output logic          done
);
  localparam logic [IW-1:0] LastIdx = IW'(LEN - 1);

  fg_state_e     state_q;
  logic [IW-1:0] cnt_q;
  logic          fire;
  logic          done_q;

  assign active = (state_q == FG_FILL);
  assign fire   = active & beat_ok;
  assign index  = cnt_q;
  assign first  = active & (cnt_q == '0);
  assign last   = active & (cnt_q == LastIdx);
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FG_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire & last;
      unique case (state_q)
        FG_IDLE: begin
          cnt_q <= '0;
          if (open_req) state_q <= FG_FILL;
        end
        FG_FILL: begin
          // Start edges are not looked at in this state: an open frame always runs to LEN.
          if (fire) begin
            if (last) begin
              state_q <= FG_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= FG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fg_sample_mux.sv
module fg_sample_mux #(
  parameter int DW = 16
) (
  input  logic          active,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          out_ready,
  output logic          in_ready,
  output logic [DW-1:0] out_data
);
  // A missing detector sample turns into a zero beat, which pads short bursts.
  assign out_data = in_valid ? in_data : '0;
  assign in_ready = active & out_ready;
endmodule

// File: rtl/fft_frame_gate.sv
module fft_frame_gate #(
  parameter int LEN = 1024,
  parameter int DW  = 16,
  parameter int IW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_index,
  output logic          out_first,
  output logic          out_last,
  output logic          frame_done
);
  generate
    if (LEN < 8 || LEN > 65536 || (LEN & (LEN - 1)) != 0) begin : g_bad_len
      $error("LEN must be a power of two from 8 to 65536");
    end
  endgenerate

  logic rise;
  logic active;

  fg_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (det_start),
    .rise_o  (rise)
  );

  fg_frame_ctrl #(.LEN(LEN), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_req (rise),
    .beat_ok  (out_ready),
    .active   (active),
    .index    (out_index),
    .first    (out_first),
    .last     (out_last),
    .done     (frame_done)
  );

  fg_sample_mux #(.DW(DW)) u_mux (
    .active    (active),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_data  (out_data)
  );

  assign out_valid = active;
endmodule

// File: rtl/fft_frame_gate_chk.sv
module fft_frame_gate_chk #(
  parameter int LEN = 1024,
  parameter int DW  = 16,
  parameter int IW  = $clog2(LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [IW-1:0] out_index,
  input logic          out_first,
  input logic          out_last,
  input logic          frame_done
);
  a_r5_first_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_valid && out_index == '0));

  a_r5_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_index == IW'(LEN - 1)));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_index == IW'($past(out_index) + 1'b1)));

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (frame_done && !out_valid));

  a_r6_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |-> (out_data == '0));

  a_r6_consume_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_valid && out_ready));
endmodule

bind fft_frame_gate fft_frame_gate_chk #(.LEN(LEN), .DW(DW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_index  (out_index),
  .out_first  (out_first),
  .out_last   (out_last),
  .frame_done (frame_done)
);

// File: tb/fft_frame_gate_test.sv
module fft_frame_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 8;
  localparam int DW  = 8;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          det_start = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b0;
  logic          in_ready, out_valid, out_first, out_last, frame_done;
  logic [DW-1:0] out_data;
  logic [IW-1:0] out_index;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fft_frame_gate #(.LEN(LEN), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .det_start(det_start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_index(out_index),
    .out_first(out_first), .out_last(out_last), .frame_done(frame_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // p selects the burst length and the ready pattern.
  // mid: raise start in the middle of the frame.
  // endst: raise start during the last transfer and hold it high.
  task automatic run_frame(input int p, input bit mid, input bit endst);
    int cnt = 0;
    int cyc = 0;
    int burst = (p == 0) ? LEN : 2 * (p - 1);
    det_start = 1'b1;
    @(negedge clk);
    det_start = 1'b0;
    check("R2 open", int'(out_valid), 1);
    check("R2 index0", int'(out_index), 0);
    while (cnt < LEN) begin
      bit rdy = (p == 0) ? 1'b1 : (((cyc * 7 + p) % 4) != 0);
      if (endst && cnt == LEN - 1) rdy = 1'b1;
      out_ready = rdy;
      in_valid  = (cnt < burst);
      in_data   = DW'(p * 16 + cnt + 1);
      if (mid) det_start = (cyc == 2);
      if (endst && cnt == LEN - 1) det_start = 1'b1;
      #1;
      check("R4 valid", int'(out_valid), 1);
      check("R3/R4 index", int'(out_index), cnt);
      check("R6 data", int'(out_data), (cnt < burst) ? p * 16 + cnt + 1 : 0);
      check("R6 in_ready", int'(in_ready), int'(rdy));
      check("R5 first", int'(out_first), int'(cnt == 0));
      check("R5 last", int'(out_last), int'(cnt == LEN - 1));
      check("R8 no early done", int'(frame_done), 0);
      if (rdy) cnt++;
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check("R8 done pulse", int'(frame_done), 1);
    check("R8 valid low", int'(out_valid), 0);
    @(negedge clk);
    check("R8 single pulse", int'(frame_done), 0);
    if (endst) begin
      for (int k = 0; k < 3; k++) begin
        check("R2/R3 held start stays idle", int'(out_valid), 0);
        @(negedge clk);
      end
      det_start = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 4000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    det_start = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 valid idle", int'(out_valid), 0);
      check("R1 in_ready idle", int'(in_ready), 0);
      check("R1 done idle", int'(frame_done), 0);
    end
    det_start = 1'b0;
    @(negedge clk);
    check("R1 still idle", int'(out_valid), 0);
    run_frame(0, 1'b0, 1'b0);
    run_frame(1, 1'b1, 1'b0);
    run_frame(2, 1'b0, 1'b0);
    run_frame(3, 1'b0, 1'b1);
    run_frame(4, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule